// File: doc/BRIEF.md
# Reversible-Gate Synchronous Up Counter

This block is a WIDTH-bit synchronous up counter. Its next-state function is made only of modeled reversible gates: Feynman (controlled-NOT) and Toffoli gates. The lines of the cascade are the count pulse, the present-state bits, and a set of zero-constant ancilla lines. One group of ancillas carries the running product of the pulse and the low state bits, so no gate needs more than two controls. A second group receives a Feynman copy of each updated state line, and these copies are fed back through a register stage to become the present state.

The gates run from the top of the running product down to bit 0. Each state bit therefore flips on the product formed from the old values of the lower bits. The ancilla lines are top-level inputs that must be held at zero, and a combinational flag reports any ancilla that is not zero. The pulse line and the product lines leave the cascade as garbage outputs, and the cascade's own updated state lines come out as a look-ahead of the next count. Physically the counter is level-sensitive, and the active clock phase must cover the full delay of the cascade. The model registers on the rising edge.

Top module: `revUpCounter`

## Requirements
- R1: With `rst` high at a rising edge, `count` becomes 0 at that edge whatever the value of `cntPulse`.
- R2: With `rst` low, all ancilla inputs zero and `cntPulse` low at a rising edge, `count` keeps its value.
- R3: With `rst` low, all ancilla inputs zero and `cntPulse` high at a rising edge, `count` becomes its old value plus one.
- R4: When `count` is all ones and `cntPulse` is high (ancillas zero, `rst` low), `count` wraps to 0 at the edge.
- R5: With ancillas zero, `garbage[0]` equals `cntPulse`, and for k from 1 to WIDTH-1, `garbage[k]` is high exactly when `cntPulse` is high and `count[k-1:0]` is all ones. The outputs are combinational.
- R6: `ancillaErr` is high in the same cycle that any bit of `ancillaIn` is 1, and low when all of its bits are 0.
- R7: The gate cascade `revGateCascade` is a bijection over its 3*WIDTH lines. Its line layout is: bit 0 is the pulse, bits 1..WIDTH are the state with bit 1 as the LSB, bits WIDTH+1..2*WIDTH-1 are the product ancillas, and bits 2*WIDTH..3*WIDTH-1 are the copy ancillas.
- R8: With ancillas zero and `rst` low, `nextCount` equals `count + cntPulse` modulo 2^WIDTH in the same cycle, and the value in `count` after the edge equals the value `nextCount` showed before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (rising edge) |
| rst | input | 1 | Synchronous reset, active high |
| cntPulse | input | 1 | Count pulse line of the cascade |
| ancillaIn | input | 2*WIDTH-1 | Zero-constant lines; low WIDTH-1 bits are product lines, upper WIDTH bits are copy lines |
| count | output | WIDTH | Registered present state |
| nextCount | output | WIDTH | Updated state lines of the cascade (combinational) |
| garbage | output | WIDTH | Pulse pass-through (bit 0) and running product lines |
| ancillaErr | output | 1 | High when any ancilla input is non-zero |

## Verification
The counting properties assume that every ancilla input is zero. Each of them is gated on that condition, because a non-zero ancilla corrupts the product lines and then the next state is no longer a count. The ancilla-flag properties are the only ones that hold under any ancilla value. The stimulus holds the ancillas at zero throughout, except in the one scenario that drives single and mixed non-zero patterns to exercise the flag. That scenario ends with a reset, so any corrupted state is cleared before other checks run. The bijection over all 4096 line patterns is exercised on a separate cascade instance, so the registered counter never sees those inputs.

// File: rtl/revCountPkg.sv
package revCountPkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic clearState;
    logic loadState;
  } cntStrobes_t;
endpackage

// File: rtl/revGateCascade.sv
// Purely reversible next-state network. Line layout:
//   [0]                    pulse
//   [WIDTH:1]              present state (bit 1 = LSB)
//   [2*WIDTH-1:WIDTH+1]    running-product ancillas
//   [3*WIDTH-1:2*WIDTH]    feedback copy ancillas
module revGateCascade #(
  parameter int WIDTH = 4
) (
  input  logic [3*WIDTH-1:0] lineIn,
  output logic [3*WIDTH-1:0] lineOut
);
  localparam int LINES   = 3 * WIDTH;
  localparam int PULSE   = 0;
  localparam int STATE0  = 1;
  localparam int PROD0   = WIDTH + 1;
  localparam int COPY0   = 2 * WIDTH;

  function automatic logic [LINES-1:0] feynman(input logic [LINES-1:0] v,
                                               input int ctl, input int tgt);
    logic [LINES-1:0] r;
    r = v;
    r[tgt] = v[tgt] ^ v[ctl];
    return r;
  endfunction

  function automatic logic [LINES-1:0] toffoli(input logic [LINES-1:0] v,
                                               input int ctlA, input int ctlB,
                                               input int tgt);
    logic [LINES-1:0] r;
    r = v;
    r[tgt] = v[tgt] ^ (v[ctlA] & v[ctlB]);
    return r;
  endfunction

  always_comb begin
    logic [LINES-1:0] v;
    v = lineIn;
    // Stage 1: running product of pulse and low state bits (old values)
    for (int k = 0; k < WIDTH - 1; k++) begin
      if (k == 0) v = toffoli(v, PULSE, STATE0, PROD0);
      else        v = toffoli(v, PROD0 + k - 1, STATE0 + k, PROD0 + k);
    end
    // Stage 2: flip state bits, most significant first
    for (int i = WIDTH - 1; i >= 1; i--) begin
      v = feynman(v, PROD0 + i - 1, STATE0 + i);
    end
    v = feynman(v, PULSE, STATE0);
    // Stage 3: copy every updated state line onto its feedback ancilla
    for (int i = 0; i < WIDTH; i++) begin
      v = feynman(v, STATE0 + i, COPY0 + i);
    end
    lineOut = v;
  end
endmodule

// File: rtl/revCountCtrl.sv
module revCountCtrl
  import revCountPkg::*;
#(
  parameter int ANC_W = 7
) (
  input  logic             rst,
  input  logic [ANC_W-1:0] ancillaIn,
  output cntStrobes_t      strobes,
  output logic             ancillaErr
);
  always_comb begin
    strobes.clearState = rst;
    strobes.loadState  = !rst;
    ancillaErr         = |ancillaIn;
  end
endmodule

// File: rtl/revCountPath.sv
module revCountPath
  import revCountPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic                 clk,
  input  cntStrobes_t          strobes,
  input  logic                 cntPulse,
  input  logic [2*WIDTH-2:0]   ancillaIn,
  output logic [WIDTH-1:0]     count,
  output logic [WIDTH-1:0]     nextCount,
  output logic [WIDTH-1:0]     garbage
);
  localparam int LINES = 3 * WIDTH;

  logic [LINES-1:0] lineIn;
  logic [LINES-1:0] lineOut;
  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] feedCopy;

  assign lineIn = {ancillaIn, stateQ, cntPulse};

  revGateCascade #(.WIDTH(WIDTH)) cascade (
    .lineIn  (lineIn),
    .lineOut (lineOut)
  );

  assign feedCopy  = lineOut[3*WIDTH-1:2*WIDTH];
  assign nextCount = lineOut[WIDTH:1];
  assign garbage   = {lineOut[2*WIDTH-1:WIDTH+1], lineOut[0]};

  always_ff @(posedge clk) begin
    if (strobes.clearState)     stateQ <= '0;
    else if (strobes.loadState) stateQ <= feedCopy;
  end

  assign count = stateQ;
endmodule

// File: rtl/revUpCounter.sv
module revUpCounter
  import revCountPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cntPulse,
  input  logic [2*WIDTH-2:0] ancillaIn,
  output logic [WIDTH-1:0]   count,
  output logic [WIDTH-1:0]   nextCount,
  output logic [WIDTH-1:0]   garbage,
  output logic               ancillaErr
);
  localparam int ANC_W = 2 * WIDTH - 1;

  cntStrobes_t strobes;

  revCountCtrl #(.ANC_W(ANC_W)) ctrl (
    .rst        (rst),
    .ancillaIn  (ancillaIn),
    .strobes    (strobes),
    .ancillaErr (ancillaErr)
  );

  revCountPath #(.WIDTH(WIDTH)) path (
    .clk       (clk),
    .strobes   (strobes),
    .cntPulse  (cntPulse),
    .ancillaIn (ancillaIn),
    .count     (count),
    .nextCount (nextCount),
    .garbage   (garbage)
  );
endmodule

// File: rtl/revUpCounterChk.sv
module revUpCounterChk #(
  parameter int WIDTH = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cntPulse,
  input logic [2*WIDTH-2:0] ancillaIn,
  input logic [WIDTH-1:0]   count,
  input logic [WIDTH-1:0]   nextCount,
  input logic [WIDTH-1:0]   garbage,
  input logic               ancillaErr
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> count == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cntPulse && ancillaIn == '0) |=> count == $past(count));

  p_incr_r3: assert property (@(posedge clk) disable iff (rst)
    (cntPulse && ancillaIn == '0) |=> count == WIDTH'($past(count) + 1'b1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (cntPulse && ancillaIn == '0 && &count) |=> count == '0);

  p_garbage_top_r5: assert property (@(posedge clk) disable iff (rst)
    (cntPulse && ancillaIn == '0 && &count) |-> &garbage);

  p_anc_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (ancillaIn != '0) |-> ancillaErr);

  p_anc_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (ancillaIn == '0) |-> !ancillaErr);

  p_lookahead_r8: assert property (@(posedge clk) disable iff (rst)
    (ancillaIn == '0) |=> count == $past(nextCount));
endmodule

bind revUpCounter revUpCounterChk #(.WIDTH(WIDTH)) chk (.*);

// File: tb/tb_revUpCounter.sv
module tb_revUpCounter;
  localparam int W     = 4;
  localparam int ANC_W = 2 * W - 1;
  localparam int LINES = 3 * W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cntPulse = 1'b0;
  logic [ANC_W-1:0] ancillaIn = '0;
  logic [W-1:0]     count, nextCount, garbage;
  logic             ancillaErr;
  logic [W-1:0]     expCount = '0;

  logic [LINES-1:0] bjIn = '0;
  logic [LINES-1:0] bjOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  revUpCounter #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .cntPulse(cntPulse), .ancillaIn(ancillaIn),
    .count(count), .nextCount(nextCount), .garbage(garbage),
    .ancillaErr(ancillaErr)
  );

  revGateCascade #(.WIDTH(W)) bjCascade (.lineIn(bjIn), .lineOut(bjOut));

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expGarbage(input logic [W-1:0] q,
                                               input logic c);
    logic [W-1:0] g;
    logic run;
    run = c;
    g[0] = c;
    for (int k = 1; k < W; k++) begin
      run = run & q[k-1];
      g[k] = run;
    end
    return g;
  endfunction

  // One clock with given pulse; checks look-ahead and registered result
  task automatic tick(input logic c, input string req);
    @(negedge clk);
    cntPulse = c;
    #1;
    if (!rst) check({req, "/R8 lookahead"}, nextCount, W'(expCount + c));
    @(posedge clk);
    expCount = rst ? '0 : W'(expCount + c);
    #1;
    check(req, count, expCount);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    cntPulse = 1'b1;
    @(posedge clk);
    expCount = '0;
    #1;
    check("R1 reset clears", count, 0);
    @(negedge clk);
    rst = 1'b0;
    cntPulse = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R6 flag low at reset", ancillaErr, 0);
    tick(1'b1, "R3 first count");
    tick(1'b1, "R3 second count");
    doReset();
  endtask

  task automatic testHold();
    tick(1'b1, "R3 before hold");
    tick(1'b1, "R3 before hold");
    tick(1'b1, "R3 before hold");
    for (int i = 0; i < 4; i++) tick(1'b0, "R2 hold");
  endtask

  task automatic testCountPattern();
    for (int i = 0; i < 40; i++) tick(((i % 3) != 0) ? 1'b1 : 1'b0, "R3 mixed pulses");
    for (int i = 0; i < 20; i++) tick(i[0], "R3 alternate pulses");
  endtask

  task automatic testWrap();
    doReset();
    for (int i = 0; i < (1 << W) - 1; i++) tick(1'b1, "R3 ramp");
    check("R4 at all ones", count, (1 << W) - 1);
    tick(1'b1, "R4 wrap");
    check("R4 wrapped to zero", count, 0);
    tick(1'b1, "R3 after wrap");
  endtask

  task automatic testGarbage();
    doReset();
    for (int i = 0; i < (1 << W); i++) begin
      @(negedge clk);
      cntPulse = 1'b0;
      #1;
      check("R5 garbage pulse low", garbage, expGarbage(count, 1'b0));
      cntPulse = 1'b1;
      #1;
      check("R5 garbage pulse high", garbage, expGarbage(count, 1'b1));
      @(posedge clk);
      expCount = W'(expCount + 1);
      #1;
    end
    check("R4 garbage sweep wrapped", count, expCount);
  endtask

  task automatic testAncilla();
    @(negedge clk);
    cntPulse = 1'b0;
    for (int b = 0; b < ANC_W; b++) begin
      ancillaIn = ANC_W'(1) << b;
      #1;
      check("R6 single ancilla set", ancillaErr, 1);
    end
    ancillaIn = {ANC_W{1'b1}};
    #1;
    check("R6 all ancillas set", ancillaErr, 1);
    ancillaIn = '0;
    #1;
    check("R6 ancillas clear", ancillaErr, 0);
    doReset();
  endtask

  task automatic testBijection();
    logic [(1<<LINES)-1:0] seen;
    int dups;
    seen = '0;
    dups = 0;
    for (int v = 0; v < (1 << LINES); v++) begin
      bjIn = LINES'(v);
      #1;
      if (seen[bjOut]) dups++;
      seen[bjOut] = 1'b1;
    end
    check("R7 no repeated output", dups, 0);
    check("R7 every output reached", $countones(seen), 1 << LINES);
    // Zero ancillas, state 0111, pulse 1 -> state lines 1000, copies 1000
    bjIn = {{ANC_W{1'b0}}, 4'b0111, 1'b1};
    #1;
    check("R7 copy lines carry next state", bjOut[LINES-1:2*W], 4'b1000);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    testReset();
    testHold();
    testCountPattern();
    testWrap();
    testGarbage();
    testAncilla();
    testHold();
    testBijection();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule